// File: doc/BRIEF.md
# Opcode-Gated Hotspot Qualifier

This block sits between a cartridge's hotspot address decoder and its bank registers. It decides whether a decoded hotspot access is deliberate. Once per processor cycle it captures the byte that is on the data bus. An access that the decoder flags as a hotspot takes effect only when the byte captured in the preceding cycle has an upper nibble of 6 or 7. That byte is the high operand byte of an absolute-addressed instruction that names the hotspot on purpose.

Dummy reads do not pass this gate, and neither do the operand fetches of instructions used to skip over others. Their preceding byte almost never falls in that window. As an extra guard, the low five bits of the preceding byte must also equal address lines A12..A8 of the current access. This holds only when that byte really was the high half of the address being used. A parameter can switch this guard off.

The output is a single-clock trigger pulse. It appears in the clock after the cycle-boundary strobe of the qualifying access, and the bank-register logic consumes it.

Top module: `hotspot_qualifier`

## Requirements
- R1: After reset the trigger is low and the stored previous byte is $00, so a flagged access in the first processor cycle after reset produces no trigger.
- R2: The previous byte is taken from the data bus only on clocks where the cycle strobe is high; data-bus values present on other clocks have no effect on later qualification.
- R3: When the cycle strobe and the raw hotspot flag are both high, the stored previous byte lies in $60..$7F, and (with page checking on) bits 4..0 of that byte equal the address page input (A12..A8), the trigger is high in the following clock.
- R4: A stored previous byte outside $60..$7F (including the edge values $5F and $80) blocks the trigger.
- R5: With page checking on, a stored previous byte in range whose bits 4..0 differ from the address page input blocks the trigger.
- R6: The trigger is high for exactly one clock per qualifying processor cycle, even when the raw flag stays high across the whole cycle.
- R7: The raw hotspot flag has no effect on clocks where the cycle strobe is low, and with the raw flag low no trigger is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, several clocks per processor cycle |
| rstN | input | 1 | Active-low synchronous reset |
| cycleStrobe | input | 1 | High for one clock at the end of each processor cycle |
| addrPage | input | 5 | Address lines A12..A8 of the current access |
| dataBus | input | 8 | Cartridge data bus |
| rawHit | input | 1 | Decoder flag: current address is a hotspot |
| trigger | output | 1 | Qualified one-clock hotspot pulse |

## Verification
The bench feeds the instruction byte streams of realistic access patterns. The first is an absolute instruction naming a $68xx hotspot, which must fire. The second is the same low address reached through a $08 high byte, and the third is a skip-over of an immediate load with operand $08; neither may fire. A $7x operand confirms that the upper half of the window is accepted. Single previous bytes at $5F, $60, $7F and $80 probe the nibble window at its edges, and an in-range byte with the wrong page separates the page guard from the nibble check. The raw flag is held high for a whole cycle to show that only one pulse results. Noise is placed on the data bus between strobes to show that only strobed bytes are remembered.

// File: rtl/hsq_pkg.sv
package hsq_pkg;
  typedef struct packed {
    logic latchEn;   // capture data bus as previous byte
    logic fireEn;    // evaluate a hotspot this clock
  } hsqCtrl_t;
endpackage

// File: rtl/hsq_datapath.sv
module hsq_datapath
  import hsq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 5,
  parameter logic [3:0] GATE_LO = 4'h6,
  parameter logic [3:0] GATE_HI = 4'h7,
  parameter bit CHECK_PAGE = 1'b1,
  parameter logic [7:0] RESET_BYTE = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  hsqCtrl_t          ctrl,
  input  logic [DATA_W-1:0] dataBus,
  input  logic [PAGE_W-1:0] addrPage,
  output logic              gateOk
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] prevByte;
  logic [NIB_W-1:0]  prevNibble;
  logic              nibbleOk;
  logic              pageOk;

  always_ff @(posedge clk) begin
    if (!rstN) prevByte <= RESET_BYTE[DATA_W-1:0];
    else if (ctrl.latchEn) prevByte <= dataBus;
  end

  assign prevNibble = prevByte[DATA_W-1 -: NIB_W];
  assign nibbleOk   = (prevNibble >= GATE_LO[NIB_W-1:0]) &&
                      (prevNibble <= GATE_HI[NIB_W-1:0]);

  generate
    if (CHECK_PAGE) begin : gPage
      assign pageOk = (prevByte[PAGE_W-1:0] == addrPage);
    end else begin : gNoPage
      logic unusedPage;
      assign unusedPage = ^addrPage;
      assign pageOk = 1'b1 | unusedPage;
    end
  endgenerate

  assign gateOk = nibbleOk && pageOk;
endmodule

// File: rtl/hsq_control.sv
module hsq_control
  import hsq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cycleStrobe,
  input  logic     rawHit,
  input  logic     gateOk,
  output hsqCtrl_t ctrl,
  output logic     trigger
);
  always_comb begin
    ctrl.latchEn = cycleStrobe;
    ctrl.fireEn  = cycleStrobe && rawHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) trigger <= 1'b0;
    else trigger <= ctrl.fireEn && gateOk;
  end
endmodule

// File: rtl/hotspot_qualifier.sv
module hotspot_qualifier
  import hsq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 5,
  parameter bit CHECK_PAGE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleStrobe,
  input  logic [PAGE_W-1:0] addrPage,
  input  logic [DATA_W-1:0] dataBus,
  input  logic              rawHit,
  output logic              trigger
);
  hsqCtrl_t ctrl;
  logic     gateOk;

  hsq_control uCtrl (
    .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe), .rawHit(rawHit),
    .gateOk(gateOk), .ctrl(ctrl), .trigger(trigger)
  );

  hsq_datapath #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .CHECK_PAGE(CHECK_PAGE)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .dataBus(dataBus),
    .addrPage(addrPage), .gateOk(gateOk)
  );
endmodule

// File: rtl/hotspot_qualifier_checker.sv
module hotspot_qualifier_checker #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 5,
  parameter bit CHECK_PAGE = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cycleStrobe,
  input logic [PAGE_W-1:0] addrPage,
  input logic [DATA_W-1:0] dataBus,
  input logic              rawHit,
  input logic              trigger
);
  logic [DATA_W-1:0] shadowByte;
  logic              seenStrobe;
  logic              shadowOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowByte <= '0;
      seenStrobe <= 1'b0;
    end else if (cycleStrobe) begin
      shadowByte <= dataBus;
      seenStrobe <= 1'b1;
    end
  end

  assign shadowOk = (shadowByte[DATA_W-1:DATA_W-4] inside {4'h6, 4'h7}) &&
                    (!CHECK_PAGE || shadowByte[PAGE_W-1:0] == addrPage);

  AST_NO_EARLY_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> $past(seenStrobe)); // R1
  AST_FIRE_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStrobe && rawHit && shadowOk) |=> trigger); // R3
  AST_BLOCK_OUT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> $past(shadowByte[DATA_W-1:DATA_W-4] inside {4'h6, 4'h7})); // R4
  AST_PAGE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && CHECK_PAGE) |-> $past(shadowByte[PAGE_W-1:0] == addrPage)); // R5
  AST_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && !$past(cycleStrobe, 1) ) |-> 1'b0); // R6
  AST_NEEDS_STROBE_HIT: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> ($past(cycleStrobe) && $past(rawHit))); // R7
endmodule

bind hotspot_qualifier hotspot_qualifier_checker #(
  .DATA_W(DATA_W), .PAGE_W(PAGE_W), .CHECK_PAGE(CHECK_PAGE)
) uChk (
  .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe), .addrPage(addrPage),
  .dataBus(dataBus), .rawHit(rawHit), .trigger(trigger)
);

// File: tb/hotspot_qualifier_test.sv
module hotspot_qualifier_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cycleStrobe = 1'b0;
  logic [4:0] addrPage = '0;
  logic [7:0] dataBus = '0;
  logic       rawHit = 1'b0;
  logic       trigger;
  int         nChecks = 0;
  int         nFails = 0;
  logic [7:0] idleNoise = 8'h00;

  always #5 clk = ~clk;

  hotspot_qualifier uut (
    .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe), .addrPage(addrPage),
    .dataBus(dataBus), .rawHit(rawHit), .trigger(trigger)
  );

  task automatic check(input string req, input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // One processor cycle: strobe for one clock, then three idle clocks.
  // rawHit is held for the whole cycle; idle clocks carry idleNoise on data.
  task automatic busCycle(input logic [12:0] addr, input logic [7:0] data,
                          input logic hit, output int pulses);
    pulses = 0;
    @(negedge clk);
    addrPage = addr[12:8];
    dataBus = data;
    rawHit = hit;
    cycleStrobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (trigger) pulses++;
    cycleStrobe = 1'b0;
    dataBus = idleNoise;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (trigger) pulses++;
    end
    rawHit = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cycleStrobe = 1'b0;
    rawHit = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    int p;
    doReset();
    check("R1 trigger low after reset", int'(trigger), 0);
    busCycle(13'h00A9, 8'h12, 1'b1, p);
    check("R1 hit right after reset", p, 0);
  endtask

  task automatic testAbsolute68();
    int p;
    doReset();
    busCycle(13'h1000, 8'h2C, 1'b0, p);
    busCycle(13'h1001, 8'hA9, 1'b0, p);
    busCycle(13'h1002, 8'h68, 1'b0, p);
    busCycle(13'h08A9, 8'h33, 1'b1, p);
    check("R3 absolute $68A9 fires once", p, 1);
    check("R6 single pulse for held hit", p, 1);
  endtask

  task automatic testHigh08();
    int p;
    doReset();
    busCycle(13'h1002, 8'h08, 1'b0, p);
    busCycle(13'h08A9, 8'h33, 1'b1, p);
    check("R4 high byte $08 blocked", p, 0);
  endtask

  task automatic testSkipImmediate();
    int p;
    doReset();
    busCycle(13'h1000, 8'h2C, 1'b0, p);
    busCycle(13'h1001, 8'h09, 1'b0, p);
    busCycle(13'h1002, 8'h08, 1'b0, p);
    busCycle(13'h0809, 8'hFF, 1'b1, p);
    check("R4 skip-over dummy read blocked", p, 0);
  endtask

  task automatic test7x();
    int p;
    doReset();
    busCycle(13'h1002, 8'h75, 1'b0, p);
    busCycle(13'h15F0, 8'h00, 1'b1, p);
    check("R3 operand $75 fires", p, 1);
  endtask

  task automatic testEdges();
    int p;
    doReset();
    busCycle(13'h1000, 8'h5F, 1'b0, p);
    busCycle(13'h1F00, 8'h00, 1'b1, p);
    check("R4 edge $5F blocked", p, 0);
    busCycle(13'h1000, 8'h80, 1'b0, p);
    busCycle(13'h0000, 8'h00, 1'b1, p);
    check("R4 edge $80 blocked", p, 0);
    busCycle(13'h1000, 8'h60, 1'b0, p);
    busCycle(13'h0000, 8'h00, 1'b1, p);
    check("R3 edge $60 fires", p, 1);
    busCycle(13'h1000, 8'h7F, 1'b0, p);
    busCycle(13'h1F00, 8'h00, 1'b1, p);
    check("R3 edge $7F fires", p, 1);
  endtask

  task automatic testPageMismatch();
    int p;
    doReset();
    busCycle(13'h1002, 8'h68, 1'b0, p);
    busCycle(13'h09A9, 8'h00, 1'b1, p);
    check("R5 page mismatch blocked", p, 0);
  endtask

  task automatic testNoHit();
    int p;
    doReset();
    busCycle(13'h1002, 8'h68, 1'b0, p);
    busCycle(13'h08A9, 8'h00, 1'b0, p);
    check("R7 no raw hit no trigger", p, 0);
  endtask

  task automatic testHitWithoutStrobe();
    int p;
    doReset();
    busCycle(13'h1002, 8'h68, 1'b0, p);
    @(negedge clk);
    addrPage = 5'h08;
    rawHit = 1'b1;
    p = 0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (trigger) p++;
    end
    rawHit = 1'b0;
    check("R7 hit without strobe ignored", p, 0);
  endtask

  task automatic testIdleNoise();
    int p;
    doReset();
    idleNoise = 8'h68;
    busCycle(13'h1002, 8'h00, 1'b0, p);
    busCycle(13'h08A9, 8'h00, 1'b1, p);
    check("R2 noise between strobes ignored", p, 0);
    idleNoise = 8'h00;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    testReset();
    testAbsolute68();
    testHigh08();
    testSkipImmediate();
    test7x();
    testEdges();
    testPageMismatch();
    testNoHit();
    testHitWithoutStrobe();
    testIdleNoise();
    summary();
  end
endmodule